// File: doc/BRIEF.md
# GPIO Interrupt Sense Controller

This block turns the levels of a 32-pin GPIO port into interrupt requests. The pin inputs must already be synchronised to the block clock. Each pin carries a 4-bit sense code, which selects rising-edge, falling-edge, both-edge, high-level or low-level detection. When a pin's condition is seen and the pin is accepted, the pin latches a pending bit. The pending bit stays set until software clears it by writing a one to its position.

A per-pin unmask state is kept separately from acceptance. Software sets unmask bits through one register and clears them through another, and in both registers only the bits written as one act. Acceptance decides whether a pin can latch a pending bit at all. Unmask decides only whether a latched bit reaches an interrupt line. There are two interrupt lines: one for pins 0 to 15 and one for pins 16 to 31. Software reads raw pending status and masked status over a simple register bus, with a one-cycle write and a registered read.

Top module: `gpio_sense_irq`

## Requirements
- R1: After a synchronous reset, acceptance, unmask, pending and every sense field read as zero, and both interrupt lines are low.
- R2: Sense code 8 sets a pin's pending bit on the clock edge at which the pin is sampled high after being sampled low on the previous edge.
- R3: Sense code 9 sets pending when the pin goes from high to low between consecutive samples.
- R4: Sense code 12 sets pending on every change of the pin in either direction.
- R5: Sense code 10 (high) and code 11 (low) set pending on every cycle that the level holds, so a pending clear takes effect only once the level has gone away.
- R6: Any sense code other than 8 to 12, including zero, never sets pending.
- R7: A pin whose bit in the acceptance register (word address 0, read/write) is zero never latches pending, whatever its sense code.
- R8: Writing word address 1 sets the unmask bits written as one, and writing address 2 clears them. Bits written as zero are unchanged. Both addresses read back the unmask state.
- R9: Writing ones to word address 3 clears those pending bits. Zero bits leave pending unchanged, a condition seen in the same cycle as the clear wins, and address 3 reads as zero.
- R10: Word address 4 reads the raw pending bits regardless of unmask. Address 5 reads pending AND unmask.
- R11: The output irq_lo is the OR of masked status bits 15:0 and irq_hi is the OR of bits 31:16. Each is registered, so it follows pending and unmask one cycle later.
- R12: The sense field of pin n is the 4-bit nibble n mod 8 (bits 4*(n mod 8)+3 down to 4*(n mod 8)) of the register at word address 8 + n/8. These four registers are read/write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Synchronised pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on the edge that samples bus_rd; held otherwise |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 |

## Verification
A pin change driven before a clock edge is latched as pending on that edge. It appears on bus_rdata after a read sampled on a later edge, and on the interrupt lines one edge after the pending bit is latched. A register write acts on the edge that samples the strobe. The bench drives all inputs on falling edges. It checks read data at the falling edge after the edge that sampled the read strobe, and it compares both interrupt lines against its model at every falling edge. The model advances on each rising edge from the previous state, so the extra register stage of the interrupt lines is matched exactly.

// File: rtl/gpio_sense_irq_pkg.sv
package gpio_sense_irq_pkg;
  localparam int SENSE_W = 4;
  localparam logic [3:0] SNS_RISE = 4'h8;
  localparam logic [3:0] SNS_FALL = 4'h9;
  localparam logic [3:0] SNS_HIGH = 4'hA;
  localparam logic [3:0] SNS_LOW  = 4'hB;
  localparam logic [3:0] SNS_BOTH = 4'hC;

  localparam int ADR_ACCEPT   = 0;
  localparam int ADR_UNM_SET  = 1;
  localparam int ADR_UNM_CLR  = 2;
  localparam int ADR_PEND_CLR = 3;
  localparam int ADR_RAW      = 4;
  localparam int ADR_MSTAT    = 5;
  localparam int ADR_SENSE0   = 8;
endpackage

// File: rtl/gpio_sense_detect.sv
module gpio_sense_detect
  import gpio_sense_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NPINS-1:0]           pin_in,
  input  logic [NPINS*SENSE_W-1:0]   sense_flat,
  output logic [NPINS-1:0]           hit
);
  logic [NPINS-1:0] pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_in;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [SENSE_W-1:0] code;
    logic cur, prev;
    assign code = sense_flat[i*SENSE_W +: SENSE_W];
    assign cur  = pin_in[i];
    assign prev = pin_q[i];
    always_comb begin
      case (code)
        SNS_RISE: hit[i] = cur & ~prev;
        SNS_FALL: hit[i] = ~cur & prev;
        SNS_HIGH: hit[i] = cur;
        SNS_LOW:  hit[i] = ~cur;
        SNS_BOTH: hit[i] = cur ^ prev;
        default:  hit[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_sense_regs.sv
module gpio_sense_regs
  import gpio_sense_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [NPINS-1:0]         hit,
  output logic [NPINS-1:0]         accept,
  output logic [NPINS-1:0]         unmask,
  output logic [NPINS-1:0]         pending,
  output logic [NPINS*SENSE_W-1:0] sense_flat
);
  localparam int FIELDS = DATA_W / SENSE_W;
  localparam int NSREG  = NPINS / FIELDS;

  logic [DATA_W-1:0] sense_r [NSREG];
  logic [NPINS-1:0]  clr_bits;
  logic [DATA_W-1:0] rd_mux;

  function automatic logic sel(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  assign clr_bits = (bus_wr && sel(bus_addr, ADR_PEND_CLR)) ? bus_wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      accept  <= '0;
      unmask  <= '0;
      pending <= '0;
    end else begin
      pending <= (pending & ~clr_bits) | (hit & accept);
      if (bus_wr && sel(bus_addr, ADR_ACCEPT))  accept <= bus_wdata[NPINS-1:0];
      if (bus_wr && sel(bus_addr, ADR_UNM_SET)) unmask <= unmask | bus_wdata[NPINS-1:0];
      if (bus_wr && sel(bus_addr, ADR_UNM_CLR)) unmask <= unmask & ~bus_wdata[NPINS-1:0];
    end
  end

  for (genvar g = 0; g < NSREG; g++) begin : g_sense
    always_ff @(posedge clk) begin
      if (rst) sense_r[g] <= '0;
      else if (bus_wr && sel(bus_addr, ADR_SENSE0 + g)) sense_r[g] <= bus_wdata;
    end
    assign sense_flat[g*DATA_W +: DATA_W] = sense_r[g];
  end

  always_comb begin
    rd_mux = '0;
    if (sel(bus_addr, ADR_ACCEPT))  rd_mux = DATA_W'(accept);
    if (sel(bus_addr, ADR_UNM_SET) || sel(bus_addr, ADR_UNM_CLR)) rd_mux = DATA_W'(unmask);
    if (sel(bus_addr, ADR_RAW))     rd_mux = DATA_W'(pending);
    if (sel(bus_addr, ADR_MSTAT))   rd_mux = DATA_W'(pending & unmask);
    for (int g = 0; g < NSREG; g++)
      if (sel(bus_addr, ADR_SENSE0 + g)) rd_mux = sense_r[g];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_sense_irq_out.sv
module gpio_sense_irq_out #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pending,
  input  logic [NPINS-1:0] unmask,
  output logic             irq_lo,
  output logic             irq_hi
);
  localparam int HALF = NPINS / 2;
  logic [NPINS-1:0] masked;
  assign masked = pending & unmask;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= |masked[HALF-1:0];
      irq_hi <= |masked[NPINS-1:HALF];
    end
  end
endmodule

// File: rtl/gpio_sense_irq.sv
module gpio_sense_irq
  import gpio_sense_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_lo,
  output logic              irq_hi
);
  logic [NPINS-1:0]         hit;
  logic [NPINS-1:0]         accept;
  logic [NPINS-1:0]         unmask;
  logic [NPINS-1:0]         pending;
  logic [NPINS*SENSE_W-1:0] sense_flat;

  gpio_sense_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst(rst), .pin_in(pin_in), .sense_flat(sense_flat), .hit(hit)
  );

  gpio_sense_regs #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hit(hit), .accept(accept),
    .unmask(unmask), .pending(pending), .sense_flat(sense_flat)
  );

  gpio_sense_irq_out #(.NPINS(NPINS)) u_out (
    .clk(clk), .rst(rst), .pending(pending), .unmask(unmask),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );
endmodule

// File: rtl/gpio_sense_irq_chk.sv
module gpio_sense_irq_chk
  import gpio_sense_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NPINS-1:0]  hit,
  input logic [NPINS-1:0]  accept,
  input logic [NPINS-1:0]  unmask,
  input logic [NPINS-1:0]  pending,
  input logic              irq_lo,
  input logic              irq_hi
);
  localparam int HALF = NPINS / 2;
  logic unm_wr, pclr_wr;
  assign unm_wr  = bus_wr && (bus_addr == ADDR_W'(ADR_UNM_SET) || bus_addr == ADDR_W'(ADR_UNM_CLR));
  assign pclr_wr = bus_wr && bus_addr == ADDR_W'(ADR_PEND_CLR);

  AST_IRQ_LO_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_lo == $past(|(pending[HALF-1:0] & unmask[HALF-1:0]))); // R11
  AST_IRQ_HI_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_hi == $past(|(pending[NPINS-1:HALF] & unmask[NPINS-1:HALF]))); // R11
  AST_NEW_PEND_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pending & ~$past(pending) & ~$past(accept)) == '0)); // R7
  AST_NEW_PEND_HAS_HIT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pending & ~$past(pending) & ~$past(hit)) == '0)); // R6
  AST_UNMASK_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(ADR_UNM_SET)) |=>
      ((unmask & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]))); // R8
  AST_UNMASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !unm_wr |=> $stable(unmask)); // R8
  AST_PEND_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    pclr_wr |=> ((pending & $past(bus_wdata[NPINS-1:0]) & ~$past(hit & accept)) == '0)); // R9
endmodule

bind gpio_sense_irq gpio_sense_irq_chk #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_sense_irq_test.sv
module gpio_sense_irq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_in = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi;

  int checks = 0, errors = 0;
  logic [31:0] rv;

  gpio_sense_irq uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirements
  logic [31:0] m_acc, m_unm, m_pend, m_prev, m_rd;
  logic [31:0] m_sense [4];
  logic        m_irq_lo, m_irq_hi;

  function automatic logic f_hit(input logic [3:0] c, input logic p, input logic n);
    case (c)
      4'd8:  return n & ~p;
      4'd9:  return ~n & p;
      4'd10: return n;
      4'd11: return ~n;
      4'd12: return n ^ p;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] f_reg(input logic [3:0] a);
    case (a)
      4'd0: return m_acc;
      4'd1, 4'd2: return m_unm;
      4'd4: return m_pend;
      4'd5: return m_pend & m_unm;
      4'd8, 4'd9, 4'd10, 4'd11: return m_sense[a - 4'd8];
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_acc = '0; m_unm = '0; m_pend = '0; m_prev = '0; m_rd = '0;
      m_irq_lo = 1'b0; m_irq_hi = 1'b0;
      for (int k = 0; k < 4; k++) m_sense[k] = '0;
    end else begin
      logic [31:0] h, clr;
      if (bus_rd) m_rd = f_reg(bus_addr);
      m_irq_lo = |(m_pend[15:0] & m_unm[15:0]);
      m_irq_hi = |(m_pend[31:16] & m_unm[31:16]);
      for (int n = 0; n < 32; n++)
        h[n] = f_hit(m_sense[n/8][(n%8)*4 +: 4], m_prev[n], pin_in[n]);
      clr = (bus_wr && bus_addr == 4'd3) ? bus_wdata : '0;
      m_pend = (m_pend & ~clr) | (h & m_acc);
      if (bus_wr) begin
        case (bus_addr)
          4'd0: m_acc = bus_wdata;
          4'd1: m_unm = m_unm | bus_wdata;
          4'd2: m_unm = m_unm & ~bus_wdata;
          4'd8, 4'd9, 4'd10, 4'd11: m_sense[bus_addr - 4'd8] = bus_wdata;
          default: ;
        endcase
      end
      m_prev = pin_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R11: interrupt lines against the model at every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R11 irq_lo", {31'd0, irq_lo}, {31'd0, m_irq_lo});
      chk("R11 irq_hi", {31'd0, irq_hi}, {31'd0, m_irq_hi});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk); pin_in = v;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq", {30'd0, irq_hi, irq_lo}, 32'd0);
    foreach (rv[i]) ;
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), rv); chk("R1 reg", rv, 32'd0);
    end

    // R8: unmask set/clear
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, rv); chk("R8 set", rv, 32'hFFFF_FFFF);
    wr(4'd2, 32'h0);
    rd(4'd2, rv); chk("R8 zero clr", rv, 32'hFFFF_FFFF);
    wr(4'd2, 32'hFFFF_0000);
    rd(4'd1, rv); chk("R8 clr", rv, 32'h0000_FFFF);
    wr(4'd1, 32'h0);
    rd(4'd1, rv); chk("R8 zero set", rv, 32'h0000_FFFF);
    wr(4'd1, 32'hFFFF_0000);

    // R12 + R2: pin 13 rising via register 9 nibble 5
    wr(4'd9, 32'h0080_0000);
    rd(4'd9, rv); chk("R12 readback", rv, 32'h0080_0000);
    pins(32'h0000_2000);
    rd(4'd4, rv); chk("R2 rise", rv, 32'h0000_2000);
    chk("R11 lo asserted", {31'd0, irq_lo}, 32'd1);
    wr(4'd3, 32'h0000_2000);
    rd(4'd4, rv); chk("R9 clear", rv, 32'd0);
    rd(4'd3, rv); chk("R9 reads zero", rv, 32'd0);

    // R3: falling on pin 13
    wr(4'd9, 32'h0090_0000);
    rd(4'd4, rv); chk("R3 no fall yet", rv, 32'd0);
    pins(32'h0);
    rd(4'd4, rv); chk("R3 fall", rv, 32'h0000_2000);
    wr(4'd3, 32'h0000_2000);

    // R4: both edges on pin 30 (register 11 nibble 6)
    wr(4'd11, 32'h0C00_0000);
    pins(32'h4000_0000);
    rd(4'd4, rv); chk("R4 up", rv, 32'h4000_0000);
    chk("R11 hi asserted", {31'd0, irq_hi}, 32'd1);
    wr(4'd3, 32'h4000_0000);
    rd(4'd4, rv); chk("R4 cleared", rv, 32'd0);
    pins(32'h0);
    rd(4'd4, rv); chk("R4 down", rv, 32'h4000_0000);
    wr(4'd3, 32'h4000_0000);

    // R5: levels on pin 17 (register 10 nibble 1)
    wr(4'd10, 32'h0000_00A0);
    pins(32'h0002_0000);
    rd(4'd4, rv); chk("R5 high", rv, 32'h0002_0000);
    wr(4'd3, 32'h0002_0000);
    rd(4'd4, rv); chk("R5 high holds", rv, 32'h0002_0000);
    pins(32'h0);
    wr(4'd3, 32'h0002_0000);
    rd(4'd4, rv); chk("R5 high gone", rv, 32'd0);
    wr(4'd10, 32'h0000_00B0);
    rd(4'd4, rv); chk("R5 low", rv, 32'h0002_0000);
    wr(4'd3, 32'h0002_0000);
    rd(4'd4, rv); chk("R5 low holds", rv, 32'h0002_0000);
    pins(32'h0002_0000);
    wr(4'd3, 32'h0002_0000);
    rd(4'd4, rv); chk("R5 low gone", rv, 32'd0);

    // R6: unsupported codes on pins 2 and 3
    wr(4'd8, 32'h0000_7D00);
    pins(32'h0002_000C);
    pins(32'h0002_0000);
    rd(4'd4, rv); chk("R6 unsupported", rv, 32'd0);

    // R7: acceptance gates pin 4 (rising)
    wr(4'd8, 32'h0008_7D00);
    wr(4'd0, 32'hFFFF_FFEF);
    pins(32'h0002_0010);
    rd(4'd4, rv); chk("R7 blocked", rv, 32'd0);
    wr(4'd0, 32'hFFFF_FFFF);
    pins(32'h0002_0000);
    pins(32'h0002_0010);
    rd(4'd4, rv); chk("R7 accepted", rv, 32'h0000_0010);

    // R10: raw vs masked
    wr(4'd2, 32'h0000_0010);
    rd(4'd4, rv); chk("R10 raw", rv, 32'h0000_0010);
    rd(4'd5, rv); chk("R10 masked off", rv, 32'd0);
    chk("R11 lo masked", {31'd0, irq_lo}, 32'd0);
    wr(4'd1, 32'h0000_0010);
    rd(4'd5, rv); chk("R10 masked on", rv, 32'h0000_0010);

    // R9: zero write leaves pending
    wr(4'd3, 32'h0);
    rd(4'd4, rv); chk("R9 zero", rv, 32'h0000_0010);
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd4, rv); chk("R9 all", rv, 32'd0);

    // Random phase against the model (R10 reads, R11 lines)
    for (int it = 0; it < 4000; it++) begin
      int op;
      op = int'($urandom % 8);
      if (op < 3) begin
        pins(pin_in ^ ($urandom & $urandom));
      end else if (op == 3) begin
        logic [31:0] d;
        for (int k = 0; k < 8; k++)
          d[k*4 +: 4] = ($urandom % 4 == 0) ? 4'($urandom) : 4'(8 + $urandom % 5);
        wr(4'(8 + $urandom % 4), d);
      end else if (op == 4) begin
        wr(4'($urandom % 3), $urandom);
      end else if (op == 5) begin
        wr(4'd3, $urandom);
      end else begin
        logic [3:0] a;
        a = 4'($urandom % 12);
        rd(a, rv); chk("R10 random read", rv, m_rd);
      end
    end

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule